// File: doc/BRIEF.md
# Best and Second-Best Search Tree

This block finds, for one agent of an auction solver, the object offering the largest net benefit, the runner-up net benefit, and the global number of the winning object. The objects are presented a block at a time: each block carries P signed net values, one per lane, with a per-lane valid bit. An agent's sweep is a run of one or more blocks, and the final block is flagged. A single result is produced per sweep.

The tree merges (valid, best, second, index) tuples through regular two-input nodes. A register stage follows every second level of the tree. The root output feeds an accumulator that folds successive blocks of a sweep together. The accumulator restarts by itself on the first block after a final block, so sweeps can follow one another without idle cycles. The result latency is fixed, so the consumer can schedule its next step without handshaking.

Top module: `best2_search`

## Requirements
- R1: For each sweep, res_best is the largest signed value among all valid lanes of all blocks in that sweep.
- R2: res_index is the global object number of the winner. This number is block_number*P + lane, where block_number counts accepted blocks from 0 at the first block of the sweep and lane is the bit position in lane_ok (value bits lane*W to lane*W+W-1 of lane_val).
- R3: When several valid objects share the largest value, res_index names the lowest global object number, whether the tied objects share a block or not.
- R4: res_second is the largest value among the valid objects other than the winner. A duplicate of the winning value therefore gives res_second equal to res_best.
- R5: With exactly one valid object in a sweep, res_second is the most negative W-bit value. With none, res_found is 0 and both res_best and res_second hold that most negative value. Otherwise res_found is 1.
- R6: res_valid is high for exactly one cycle per sweep, LAT = 2*ceil(log2(P)/2) rising edges after the edge that accepts the final block (LAT = 4 for P = 16), and is low at all other times.
- R7: A block is accepted on every edge where blk_valid is high, with no gap needed between blocks or between sweeps. A sweep's result is unaffected by the blocks of the sweep that follows it.
- R8: While rst_n is low, and until a final block has been accepted, res_valid is 0. After reset the next accepted block is block 0 of a new sweep.
- R9: A lane whose lane_ok bit is 0 takes no part in the result, whatever its value.
- R10: On edges where blk_valid is low, lane_ok, lane_val and blk_last are ignored and the block number does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| blk_valid | input | 1 | A block of lanes is presented this cycle |
| blk_last | input | 1 | The presented block ends the current sweep |
| lane_ok | input | P | Per-lane valid bits |
| lane_val | input | P*W | Per-lane signed net values, lane i in bits i*W+W-1 to i*W |
| res_valid | output | 1 | Result strobe, one cycle per sweep |
| res_found | output | 1 | At least one valid object was seen in the sweep |
| res_best | output | W | Largest valid value (two's complement) |
| res_second | output | W | Runner-up valid value (two's complement) |
| res_index | output | IDXW | Global object number of the winner |

## Verification
A corrupted tuple inside a tree node or in the accumulator shows up as a wrong winner, a wrong runner-up or a wrong index on the very next result strobe. That strobe comes LAT cycles after the final block, and this is the only point where the state becomes visible. A slip between the data stages and the valid/last/block-number pipeline appears at the same strobe. It shows either as a strobe in the wrong cycle or as values merged from the wrong block, which surfaces as index errors in sweeps of several blocks. A fault in the tie rule or in restarting the accumulator only shows with tied values or with sweeps run back to back, so stimulus is built to produce exactly those cases.

// File: rtl/best2_search.sv
module best2_search #(
  parameter int P    = 16,
  parameter int W    = 16,
  parameter int IDXW = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            blk_valid,
  input  logic            blk_last,
  input  logic [P-1:0]    lane_ok,
  input  logic [P*W-1:0]  lane_val,
  output logic            res_valid,
  output logic            res_found,
  output logic [W-1:0]    res_best,
  output logic [W-1:0]    res_second,
  output logic [IDXW-1:0] res_index
);
  localparam int LW  = $clog2(P);
  localparam int S   = (LW + 1) / 2;
  localparam int LAT = 2 * S;
  localparam int DLY = LAT - S + 1;
  localparam int BW  = IDXW - LW;
  localparam logic [W-1:0] NEG = {1'b1, {(W-1){1'b0}}};

  typedef struct packed {
    logic            v;
    logic [W-1:0]    b;
    logic [W-1:0]    s;
    logic [IDXW-1:0] i;
  } tup_t;

  // a wins ties, so a must hold the lower object numbers
  function automatic tup_t mrg(input tup_t a, input tup_t c);
    tup_t w, l, o;
    logic aw;
    aw = a.v && (!c.v || ($signed(a.b) >= $signed(c.b)));
    w  = aw ? a : c;
    l  = aw ? c : a;
    o  = w;
    o.v = a.v | c.v;
    if (l.v && ($signed(l.b) > $signed(w.s))) o.s = l.b;
    return o;
  endfunction

  tup_t nd [1:2*P-1];

  for (genvar n = P; n < 2*P; n++) begin : g_leaf
    assign nd[n] = '{v: lane_ok[n-P],
                     b: lane_ok[n-P] ? lane_val[(n-P)*W +: W] : NEG,
                     s: NEG,
                     i: IDXW'(n-P)};
  end

  for (genvar n = 1; n < P; n++) begin : g_node
    localparam int D  = $clog2(n + 1) - 1;
    localparam int LV = LW - D;
    tup_t m;
    assign m = mrg(nd[2*n], nd[2*n+1]);
    if ((LV % 2 == 0) || (D == 0)) begin : g_reg
      tup_t r;
      always_ff @(posedge clk) r <= m;
      assign nd[n] = r;
    end else begin : g_comb
      assign nd[n] = m;
    end
  end

  logic [S-1:0]  pv, pl;
  logic [BW-1:0] pb [S];
  logic [BW-1:0] bcnt;
  logic [DLY-1:0] dv;
  tup_t dl [DLY];
  tup_t tin, acc, nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv   <= '0;
      dv   <= '0;
      bcnt <= '0;
    end else begin
      pv[0] <= blk_valid;
      dv[0] <= pv[S-1] & pl[S-1];
      for (int k = 1; k < S; k++) pv[k] <= pv[k-1];
      for (int k = 1; k < DLY; k++) dv[k] <= dv[k-1];
      if (blk_valid) bcnt <= blk_last ? '0 : bcnt + 1'b1;
    end
  end

  always_comb begin
    tin   = nd[1];
    tin.i = nd[1].i | {pb[S-1], {LW{1'b0}}};
    nx    = (pb[S-1] == '0) ? tin : mrg(acc, tin);
  end

  always_ff @(posedge clk) begin
    pl[0] <= blk_last;
    pb[0] <= bcnt;
    for (int k = 1; k < S; k++) begin
      pl[k] <= pl[k-1];
      pb[k] <= pb[k-1];
    end
    if (pv[S-1]) acc <= nx;
    dl[0] <= nx;
    for (int k = 1; k < DLY; k++) dl[k] <= dl[k-1];
  end

  assign res_valid  = dv[DLY-1];
  assign res_found  = dl[DLY-1].v;
  assign res_best   = dl[DLY-1].b;
  assign res_second = dl[DLY-1].s;
  assign res_index  = dl[DLY-1].i;
endmodule

// File: rtl/best2_search_chk.sv
module best2_search_chk #(
  parameter int P    = 16,
  parameter int W    = 16,
  parameter int IDXW = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic         blk_valid,
  input logic         blk_last,
  input logic [P-1:0] lane_ok,
  input logic         res_valid,
  input logic         res_found,
  input logic [W-1:0] res_best,
  input logic [W-1:0] res_second
);
  localparam int LW  = $clog2(P);
  localparam int LAT = 2 * ((LW + 1) / 2);
  localparam logic [W-1:0] NEG = {1'b1, {(W-1){1'b0}}};
  localparam int CHK_IDXW = IDXW;

  logic [LAT:0] sh, shf;
  logic seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      shf  <= '0;
      seen <= 1'b0;
    end else begin
      sh[0]  <= blk_valid & blk_last;
      shf[0] <= seen | (|lane_ok);
      for (int k = 1; k <= LAT; k++) begin
        sh[k]  <= sh[k-1];
        shf[k] <= shf[k-1];
      end
      if (blk_valid) seen <= blk_last ? 1'b0 : (seen | (|lane_ok));
    end
  end

  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid == sh[LAT]);

  p_found_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_found == shf[LAT]));

  p_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_found) |-> (res_best == NEG && res_second == NEG));

  p_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_found) |-> ($signed(res_second) <= $signed(res_best)));
endmodule

bind best2_search best2_search_chk #(.P(P), .W(W), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_last(blk_last),
  .lane_ok(lane_ok), .res_valid(res_valid), .res_found(res_found),
  .res_best(res_best), .res_second(res_second));

// File: tb/best2_search_test.sv
module best2_search_test;
  localparam int P = 16, W = 16, IDXW = 10, LAT = 4, MAXB = 8;
  localparam int NEG = -32768;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, blk_valid, blk_last;
  logic [P-1:0] lane_ok;
  logic [P*W-1:0] lane_val;
  logic res_valid, res_found;
  logic [W-1:0] res_best, res_second;
  logic [IDXW-1:0] res_index;

  best2_search #(.P(P), .W(W), .IDXW(IDXW)) uut (
    .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_last(blk_last),
    .lane_ok(lane_ok), .lane_val(lane_val), .res_valid(res_valid),
    .res_found(res_found), .res_best(res_best), .res_second(res_second),
    .res_index(res_index));

  typedef struct {
    int best; int second; int idx; bit found; int due; string tag;
  } exp_t;
  exp_t q[$];

  int cyc = 0, checks = 0, errors = 0;
  int vals [MAXB*P];
  bit oks  [MAXB*P];
  int unsigned seed = 32'h1234_5678;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int rnd(int lo, int hi);
    seed = seed * 32'd1664525 + 32'd1013904223;
    return lo + int'((seed >> 8) % unsigned'(hi - lo + 1));
  endfunction

  task automatic check(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic fill(int nb, int lo, int hi, int okpct);
    for (int j = 0; j < nb*P; j++) begin
      vals[j] = rnd(lo, hi);
      oks[j]  = (rnd(0, 99) < okpct);
    end
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      blk_valid = 1'b0;
      blk_last  = 1'b0;
    end
  endtask

  task automatic run_agent(int nb, int gap, string tag);
    exp_t e;
    e.found = 0; e.best = NEG; e.second = NEG; e.idx = 0; e.tag = tag;
    for (int j = 0; j < nb*P; j++) begin
      if (oks[j]) begin
        if (!e.found || vals[j] > e.best) begin
          e.second = e.found ? e.best : NEG;
          e.best = vals[j]; e.idx = j; e.found = 1;
        end else if (vals[j] > e.second) begin
          e.second = vals[j];
        end
      end
    end
    for (int b = 0; b < nb; b++) begin
      @(negedge clk);
      blk_valid = 1'b1;
      blk_last  = (b == nb - 1);
      for (int l = 0; l < P; l++) begin
        lane_ok[l] = oks[b*P + l];
        lane_val[l*W +: W] = W'(vals[b*P + l]);
      end
      if (b == nb - 1) begin
        e.due = cyc + 1 + LAT;
        q.push_back(e);
      end else begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          blk_valid = 1'b0;
          blk_last  = 1'b1;
          lane_ok   = '1;
          lane_val  = {P{16'h7fff}};
        end
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R6 unexpected res_valid got 1 expected 0");
      end else begin
        exp_t e;
        e = q.pop_front();
        check({e.tag, " R6"}, "cycle", cyc, e.due);
        check({e.tag, " R5"}, "found", int'(res_found), int'(e.found));
        check({e.tag, " R1"}, "best", int'($signed(res_best)), e.best);
        check({e.tag, " R4"}, "second", int'($signed(res_second)), e.second);
        if (e.found) check({e.tag, " R2"}, "index", int'(res_index), e.idx);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R6 got 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; blk_valid = 1'b0; blk_last = 1'b0;
    lane_ok = '0; lane_val = '0;
    repeat (3) @(negedge clk);
    check("R8", "res_valid in reset", int'(res_valid), 0);
    rst_n = 1'b1;
    idle(3);
    check("R8", "res_valid after reset", int'(res_valid), 0);

    fill(1, -32768, 32767, 100);
    run_agent(1, 0, "R1 R2 R4 single block");

    fill(4, -32768, 32767, 70);
    run_agent(4, 0, "R1 R2 R9 four blocks");

    fill(1, -100, 100, 100);
    vals[3] = 500; vals[9] = 500;
    run_agent(1, 0, "R3 R4 tie in block");

    fill(3, -100, 100, 100);
    vals[12] = 700; vals[2*P + 1] = 700;
    run_agent(3, 0, "R3 R7 tie across blocks");

    fill(2, -100, 100, 0);
    oks[P + 6] = 1; vals[P + 6] = -5;
    run_agent(2, 0, "R5 one valid");

    fill(2, -32768, 32767, 0);
    run_agent(2, 0, "R5 none valid");

    fill(2, -50, 50, 100);
    for (int j = 0; j < 2*P; j += 3) begin oks[j] = 0; vals[j] = 32767; end
    run_agent(2, 0, "R9 masked large");

    fill(3, -1000, 1000, 80);
    run_agent(3, 2, "R10 gaps ignored");
    idle(2);

    for (int a = 0; a < 5; a++) begin
      fill(1, -2000, 2000, 90);
      run_agent(1, 0, "R7 R6 back to back");
    end

    fill(8, -32768, 32767, 60);
    vals[5] = NEG; oks[5] = 1;
    run_agent(8, 0, "R1 R2 long sweep");
    idle(1);

    for (int a = 0; a < 20; a++) begin
      int nb;
      nb = rnd(1, MAXB);
      fill(nb, -300, 300, 75);
      run_agent(nb, rnd(0, 1), "R1 R3 R7 random");
    end

    idle(LAT + 6);
    check("R6", "pending results", q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule